// File: doc/BRIEF.md
# NAND Write Cycle Timing Generator

This block shapes the strobes of one write transfer on an 8-bit NAND flash bus, counted in system clock cycles. A requester presents a kind (command, address or data) with either one byte or a packed multi-byte address. Once the request is taken, the block runs each bus beat through three timed phases. The first is a latch-setup phase, where the command or address latch enable is raised while the write strobe stays high. The second is a strobe phase, where the write strobe is low and the byte is on the bus. The third is a hold phase, where the strobe is back high and the byte is still driven.

For an address request, the block sends the bytes of the packed address one after another, least significant byte first. The number of beats depends on two inputs: a page-size selector (small or large page) and an extra-cycle bit. The three phase lengths and the beat count are captured when the request is taken. They then apply to the whole request, so a requester can reprogram them freely while a transfer is running.

The controller is a four-state machine. It has the states IDLE, SETUP, STROBE and HOLD, and these transitions:
- IDLE→SETUP when a request is taken and the setup length is nonzero.
- IDLE→STROBE when a request is taken and the setup length is zero.
- SETUP→STROBE when the setup count expires.
- STROBE→HOLD when the strobe count expires.
- HOLD→SETUP or HOLD→STROBE when the hold count expires and more address beats remain. The target depends on whether the setup length is nonzero.
- HOLD→IDLE when the hold count expires on the last beat.

Top module: `nand_wr_cycle_gen`

## Requirements
- R1: A request is taken at a clock edge where `req_valid` is high, `busy` is low and `req_kind` is 0 (command), 1 (address) or 2 (data), and `busy` is high from the next cycle on. The kind value 3 is never taken.
- R2: Each beat starts with `cfg_setup` cycles in which the latch enable for the kind is high, `nand_we_n` is high and `nand_dq_oe` is low. A value of 0 omits this phase.
- R3: After the setup phase, `nand_we_n` is low and `nand_dq_oe` is high for `cfg_strobe`+1 cycles, with the beat's byte on `nand_dq`. It never stays low longer than 2^PHASE_W cycles in a row.
- R4: After the strobe phase, `nand_we_n` is high and `nand_dq_oe` stays high with the same byte for `cfg_hold`+1 cycles.
- R5: `nand_cle` is high only during a command request and `nand_ale` only during an address request. They are never high together, and neither changes while `busy` stays high.
- R6: An address request issues 3 + `cfg_big_page` + `cfg_addr_extra` beats: 3 or 4 in small-page mode (`cfg_big_page`=0), and 4 or 5 in large-page mode. Beat n carries `req_addr[8n+7:8n]`, and the beats follow back to back, each with all three phases.
- R7: `busy` stays high from the cycle after the request is taken until the last hold phase ends, which is beats×(`cfg_setup`+`cfg_strobe`+`cfg_hold`+2) cycles. Requests presented while `busy` is high have no effect.
- R8: The phase lengths, the page-size selector, the extra-cycle bit and the byte values are captured when a request is taken. Changes made during a transfer do not alter it and apply to the next request.
- R9: During and right after reset, `busy`, `nand_cle`, `nand_ale` and `nand_dq_oe` are low and `nand_we_n` is high, even if reset cuts a transfer short.
- R10: Whenever `busy` is low, the bus is quiet: `nand_we_n` is high, both latch enables and `nand_dq_oe` are low, and `nand_dq` is 0. `nand_dq` is also 0 in every cycle where `nand_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 command, 1 address, 2 data, 3 ignored |
| req_data | input | BYTE_W | Byte for a command or data request |
| req_addr | input | ADDR_BYTES*BYTE_W | Packed address, low byte sent first |
| cfg_setup | input | PHASE_W | Latch-setup length in cycles (0 to 7) |
| cfg_strobe | input | PHASE_W | Strobe-low length minus one |
| cfg_hold | input | PHASE_W | Hold length minus one |
| cfg_big_page | input | 1 | 0 small page, 1 large page |
| cfg_addr_extra | input | 1 | Adds one address beat |
| busy | output | 1 | Transfer in progress |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq | output | BYTE_W | Bus byte, 0 when not driven |
| nand_dq_oe | output | 1 | Bus output enable |

## Verification
The bench builds the block with its defaults: BYTE_W=8, PHASE_W=3 and ADDR_BYTES=5. At these values every phase length from 0 to 7 and every beat count from 3 to 5 can be reached in a few hundred cycles. The table drives both extremes of all three phase fields, a zero-length setup phase, and all four page-size and extra-bit combinations. With five address bytes, the large-page five-beat case carries a distinct byte in every lane, so a wrong byte order or a missing beat shows up on the bus.

// File: rtl/nwc_pkg.sv
package nwc_pkg;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2,
        KIND_RSVD = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } bus_state_e;

    localparam int SMALL_PAGE_ADDR_BEATS = 3;

endpackage

// File: rtl/nwc_addr_cycles.sv
module nwc_addr_cycles #(
    parameter int CNT_W      = 3,
    parameter int BASE_BEATS = 3
) (
    input  logic             big_page,
    input  logic             extra,
    output logic [CNT_W-1:0] beats_m1
);
    // Beat count minus one: small page gives BASE or BASE+1, large page one more.
    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BASE_BEATS - 1);

    always_comb begin
        beats_m1 = BASE_M1 + CNT_W'(big_page) + CNT_W'(extra);
    end
endmodule

// File: rtl/nwc_phase_timer.sv
module nwc_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/nwc_byte_shifter.sv
module nwc_byte_shifter #(
    parameter int BYTE_W = 8,
    parameter int BYTES  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [BYTES*BYTE_W-1:0]   load_val,
    input  logic                      shift,
    output logic [BYTE_W-1:0]         cur_byte
);
    localparam int TOTAL_W = BYTES * BYTE_W;

    logic [TOTAL_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= load_val;
        end else if (shift) begin
            data_q <= {{BYTE_W{1'b0}}, data_q[TOTAL_W-1:BYTE_W]};
        end
    end

    assign cur_byte = data_q[BYTE_W-1:0];
endmodule

// File: rtl/nand_wr_cycle_gen.sv
module nand_wr_cycle_gen
    import nwc_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int PHASE_W    = 3,
    parameter int ADDR_BYTES = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [1:0]                   req_kind,
    input  logic [BYTE_W-1:0]            req_data,
    input  logic [ADDR_BYTES*BYTE_W-1:0] req_addr,
    input  logic [PHASE_W-1:0]           cfg_setup,
    input  logic [PHASE_W-1:0]           cfg_strobe,
    input  logic [PHASE_W-1:0]           cfg_hold,
    input  logic                         cfg_big_page,
    input  logic                         cfg_addr_extra,
    output logic                         busy,
    output logic                         nand_cle,
    output logic                         nand_ale,
    output logic                         nand_we_n,
    output logic [BYTE_W-1:0]            nand_dq,
    output logic                         nand_dq_oe
);
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
    localparam int BEAT_W = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [PHASE_W-1:0] SETUP_RST = PHASE_W'(1);

    bus_state_e          state_q, state_d;
    req_kind_e           kind_q;
    logic [PHASE_W-1:0]  setup_q, strobe_q, hold_q;
    logic [BEAT_W-1:0]   beats_q, beats_m1;
    logic                accept;
    logic                tmr_load, tmr_done;
    logic [PHASE_W-1:0]  tmr_val;
    logic                shift_en;
    logic [ADDR_W-1:0]   load_bytes;
    logic [BYTE_W-1:0]   cur_byte;

    assign accept = (state_q == ST_IDLE) && req_valid &&
                    (req_kind != KIND_RSVD);

    assign load_bytes = (req_kind == KIND_ADDR) ? req_addr : ADDR_W'(req_data);

    nwc_addr_cycles #(
        .CNT_W      (BEAT_W),
        .BASE_BEATS (SMALL_PAGE_ADDR_BEATS)
    ) u_addr_cycles (
        .big_page (cfg_big_page),
        .extra    (cfg_addr_extra),
        .beats_m1 (beats_m1)
    );

    nwc_phase_timer #(
        .W (PHASE_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    nwc_byte_shifter #(
        .BYTE_W (BYTE_W),
        .BYTES  (ADDR_BYTES)
    ) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_bytes),
        .shift    (shift_en),
        .cur_byte (cur_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request snapshot: timing, kind and beat count frozen for the transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= KIND_CMD;
            setup_q  <= SETUP_RST;
            strobe_q <= '0;
            hold_q   <= '0;
            beats_q  <= '0;
        end else if (accept) begin
            kind_q   <= req_kind_e'(req_kind);
            setup_q  <= cfg_setup;
            strobe_q <= cfg_strobe;
            hold_q   <= cfg_hold;
            beats_q  <= (req_kind == KIND_ADDR) ? beats_m1 : '0;
        end else if (shift_en) begin
            beats_q  <= beats_q - BEAT_W'(1);
        end
    end

    // Next state and phase timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (cfg_setup != '0) begin
                        state_d = ST_SETUP;
                        tmr_val = cfg_setup - PHASE_W'(1);
                    end else begin
                        state_d = ST_STROBE;
                        tmr_val = cfg_strobe;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = strobe_q;
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = hold_q;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    if (beats_q == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        shift_en = 1'b1;
                        tmr_load = 1'b1;
                        if (setup_q != '0) begin
                            state_d = ST_SETUP;
                            tmr_val = setup_q - PHASE_W'(1);
                        end else begin
                            state_d = ST_STROBE;
                            tmr_val = strobe_q;
                        end
                    end
                end
            end
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        busy       = (state_q != ST_IDLE);
        nand_we_n  = (state_q != ST_STROBE);
        nand_dq_oe = (state_q == ST_STROBE) || (state_q == ST_HOLD);
        nand_cle   = busy && (kind_q == KIND_CMD);
        nand_ale   = busy && (kind_q == KIND_ADDR);
        nand_dq    = nand_dq_oe ? cur_byte : '0;
    end
endmodule

// File: rtl/nwc_checker.sv
module nwc_checker #(
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              busy,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic [BYTE_W-1:0] nand_dq,
    input logic              nand_dq_oe
);
    localparam int RUN_W = PHASE_W + 2;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(1 << PHASE_W);

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!nand_we_n) begin
            if (low_run != {RUN_W{1'b1}}) low_run <= low_run + RUN_W'(1);
        end else begin
            low_run <= '0;
        end
    end

    // R1: a transfer only starts after a valid, non-reserved request
    p_start_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(req_valid) && ($past(req_kind) != 2'd3)));

    // R3: strobe low implies the bus is driven
    p_strobe_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);

    // R3: byte steady while the strobe stays low
    p_dq_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq));

    // R3: strobe-low run bounded by the phase field range
    p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= RUN_MAX);

    // R5: latch enables exclusive
    p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R5: latch enables steady across a transfer
    p_latch_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(nand_cle) && $stable(nand_ale)));

    // R10: quiet bus when idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && !nand_cle && !nand_ale && !nand_dq_oe &&
                   (nand_dq == '0)));

    // R10: undriven bus reads zero
    p_undriven_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_dq_oe |-> (nand_dq == '0));
endmodule

bind nand_wr_cycle_gen nwc_checker #(
    .BYTE_W  (BYTE_W),
    .PHASE_W (PHASE_W)
) u_nwc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .busy       (busy),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_dq    (nand_dq),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_wr_cycle_gen_bench.sv
module nand_wr_cycle_gen_bench;
    localparam int BW = 8;
    localparam int PW = 3;
    localparam int AB = 5;
    localparam int AW = AB * BW;
    localparam int NVEC = 8;

    // {kind[1:0], setup[2:0], strobe[2:0], hold[2:0], big, extra, addr[39:0]}
    localparam logic [52:0] VECS [0:NVEC-1] = '{
        {2'd0, 3'd1, 3'd0, 3'd0, 1'b0, 1'b0, 40'h00_0000_0070},
        {2'd2, 3'd0, 3'd2, 3'd1, 1'b0, 1'b0, 40'h00_0000_00A5},
        {2'd0, 3'd7, 3'd7, 3'd7, 1'b0, 1'b0, 40'h00_0000_003C},
        {2'd1, 3'd2, 3'd1, 3'd0, 1'b0, 1'b0, 40'h00_0033_2211},
        {2'd1, 3'd0, 3'd0, 3'd0, 1'b0, 1'b1, 40'h00_D4C3_B2A1},
        {2'd1, 3'd1, 3'd3, 3'd2, 1'b1, 1'b0, 40'h00_8877_6655},
        {2'd1, 3'd3, 3'd0, 3'd4, 1'b1, 1'b1, 40'h5E_4D3C_2B1A},
        {2'd2, 3'd5, 3'd4, 3'd3, 1'b0, 1'b0, 40'h00_0000_00FF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [BW-1:0] req_data = '0;
    logic [AW-1:0] req_addr = '0;
    logic [PW-1:0] cfg_setup = 3'd1;
    logic [PW-1:0] cfg_strobe = 3'd0;
    logic [PW-1:0] cfg_hold = 3'd0;
    logic          cfg_big_page = 1'b0;
    logic          cfg_addr_extra = 1'b0;
    logic          busy, nand_cle, nand_ale, nand_we_n, nand_dq_oe;
    logic [BW-1:0] nand_dq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nand_wr_cycle_gen #(.BYTE_W(BW), .PHASE_W(PW), .ADDR_BYTES(AB)) u_nand_wr_cycle_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .req_addr(req_addr), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_big_page(cfg_big_page),
        .cfg_addr_extra(cfg_addr_extra), .busy(busy), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_dq(nand_dq),
        .nand_dq_oe(nand_dq_oe)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Idle bus pattern packed as {busy, cle, ale, we_n, oe, dq}
    function automatic logic [12:0] bus_now();
        return {busy, nand_cle, nand_ale, nand_we_n, nand_dq_oe, nand_dq};
    endfunction

    localparam logic [12:0] IDLE_BUS = {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00};

    task automatic run_req(input logic [1:0] kind, input logic [2:0] ta,
                           input logic [2:0] t0, input logic [2:0] t1,
                           input bit big, input bit ext, input logic [AW-1:0] addr,
                           input bit spam, input bit chg);
        int beats, blen, total, i, pos, b;
        bit ph_bad, lat_bad, dq_bad;
        logic [BW-1:0] exp_dq, bad_dq, got_dq;
        logic exp_we, exp_oe;
        ph_bad = 0; lat_bad = 0; dq_bad = 0; bad_dq = '0; got_dq = '0;
        @(negedge clk);
        cfg_setup = ta; cfg_strobe = t0; cfg_hold = t1;
        cfg_big_page = big; cfg_addr_extra = ext;
        req_valid = 1'b1; req_kind = kind; req_data = addr[7:0]; req_addr = addr;
        @(negedge clk);
        if (spam) begin
            req_kind = 2'd0; req_data = ~addr[7:0]; req_addr = ~addr;
        end else begin
            req_valid = 1'b0;
        end
        beats = (kind == 2'd1) ? (3 + int'(big) + int'(ext)) : 1;
        blen  = int'(ta) + int'(t0) + int'(t1) + 2;
        total = beats * blen;
        i = 0;
        while (busy && i < 400) begin
            pos = i % blen;
            b   = i / blen;
            exp_we = !(pos >= int'(ta) && pos < int'(ta) + int'(t0) + 1);
            exp_oe = (pos >= int'(ta));
            exp_dq = exp_oe ? addr[8*b +: 8] : 8'h00;
            if (nand_we_n !== exp_we || nand_dq_oe !== exp_oe) ph_bad = 1;
            if (nand_cle !== (kind == 2'd0) || nand_ale !== (kind == 2'd1)) lat_bad = 1;
            if (nand_dq !== exp_dq && !dq_bad) begin
                dq_bad = 1; bad_dq = exp_dq; got_dq = nand_dq;
            end
            if (chg && i == 1) begin
                cfg_setup = ~ta; cfg_strobe = ~t0; cfg_hold = ~t1;
                cfg_big_page = ~big; cfg_addr_extra = ~ext;
            end
            i++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (kind == 2'd1)
            check(i == total, "R6", "address beats x beat length", i, total);
        else
            check(i == total, "R7", "busy cycles", i, total);
        check(!ph_bad, "R2/R3/R4", "setup/strobe/hold pattern", ph_bad, 0);
        check(!lat_bad, "R5", "latch enable per kind", lat_bad, 0);
        check(!dq_bad, (kind == 2'd1) ? "R6" : "R3", "bus byte", got_dq, bad_dq);
        check(bus_now() == IDLE_BUS, "R10", "bus after transfer", bus_now(), IDLE_BUS);
        if (spam) begin
            @(negedge clk);
            check(busy == 1'b0, "R7", "request during busy ignored", busy, 0);
        end
        if (chg) begin
            check(i == total, "R8", "captured settings held", i, total);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(bus_now() == IDLE_BUS, "R9", "bus in reset", bus_now(), IDLE_BUS);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_now() == IDLE_BUS, "R9", "bus after reset", bus_now(), IDLE_BUS);

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            run_req(VECS[k][52:51], VECS[k][50:48], VECS[k][47:45], VECS[k][44:42],
                    VECS[k][41], VECS[k][40], VECS[k][39:0], 1'b0, 1'b0);
        end

        // R1: reserved kind is not taken
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd3; req_data = 8'h99;
        @(negedge clk);
        check(busy == 1'b0, "R1", "reserved kind taken", busy, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_now() == IDLE_BUS, "R1", "bus after reserved kind", bus_now(), IDLE_BUS);

        // R7: request held high through a transfer is ignored
        run_req(2'd2, 3'd2, 3'd1, 3'd2, 1'b0, 1'b0, 40'h00_0000_005A, 1'b1, 1'b0);

        // R8: settings changed mid-transfer, then used on the next request
        run_req(2'd1, 3'd1, 3'd2, 3'd1, 1'b0, 1'b0, 40'h00_00C3_B2A1, 1'b0, 1'b1);
        run_req(2'd1, 3'd6, 3'd5, 3'd6, 1'b1, 1'b1, 40'h11_2233_4455, 1'b0, 1'b0);

        // R9: reset cuts a transfer short
        @(negedge clk);
        cfg_setup = 3'd2; cfg_strobe = 3'd5; cfg_hold = 3'd5;
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 40'h01_0203_0405;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b1 && nand_we_n == 1'b0, "R3", "strobe low mid-transfer",
              {busy, nand_we_n}, 2'b10);
        rst_n = 1'b0;
        #1;
        check(bus_now() == IDLE_BUS, "R9", "bus under reset mid-transfer", bus_now(), IDLE_BUS);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_now() == IDLE_BUS, "R9", "bus after mid-transfer reset", bus_now(), IDLE_BUS);

        // After reset, a default-timing command runs again
        run_req(2'd0, 3'd1, 3'd0, 3'd0, 1'b0, 1'b0, 40'h00_0000_00FF, 1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule